// File: doc/BRIEF.md
# Table-free mesh route selector

This unit computes the output-port choice for one router of a two-dimensional mesh network-on-chip. It uses no routing table. A packet header supplies signed X and Y offsets to the destination, where positive X points East and positive Y points North. The unit combines these offsets with four small per-port configuration registers and returns a five-bit port mask over North, East, South, West and Local. The mask is computed with combinational gate logic in the same cycle, so the unit does not depend on the buffering, arbitration or switching style around it.

Each configuration register sets four things for its port. It says whether the link is present. It holds two turn permissions that tell whether a packet leaving through that port may turn at the next hop. It marks whether the port is a branch of the region's broadcast tree. The same gate logic therefore covers a full mesh with X-then-Y routing, a mesh with failed links, and a mesh split into regions. In broadcast mode the unit copies the packet to Local and to every tree branch except the port it came in on.

Top module: `lbdr_route`

## Requirements
- R1: After reset the registers hold North/South = 8'h09 and East/West = 8'h0F. With these values unicast routing is pure X-then-Y. A nonzero X offset selects East (X>0) or West (X<0). Otherwise a nonzero Y offset selects North (Y>0) or South (Y<0).
- R2: In unicast mode, when both offsets are zero, the output is exactly the Local bit (mask 5'b10000).
- R3: In unicast mode, a direction bit is set only if it is productive: East needs X>0, West needs X<0, North needs Y>0 and South needs Y<0.
- R4: A productive port whose offset on the other axis is zero is eligible. When the other axis also needs a move, the port is eligible only if the matching turn bit is set. For North and South ports, bit 1 allows a later East turn and bit 2 allows a later West turn. For East and West ports, bit 1 allows a later North turn and bit 2 allows a later South turn.
- R5: If a port's register bit 0 (link present) is 0, that port's mask bit is 0 in both modes.
- R6: In unicast mode at most one bit is set. Among eligible ports, the X-axis port wins over the Y-axis port. If no port is eligible and the offsets are nonzero, the mask is zero.
- R7: In broadcast mode the offsets have no effect. The Local bit is always set. Each of North, East, South and West is set when both its bit 0 and bit 3 (tree branch) are 1 and it is not the arrival port. Arrival port codes are 0 = North, 1 = East, 2 = South, 3 = West and 4 = Local.
- R8: A write with enable high loads the data into the register chosen by the address (0 = North, 1 = East, 2 = South, 3 = West). The new value steers the route from the next cycle. Writes to addresses 4 to 7 change nothing.
- R9: Register bits 7:4 have no effect on the port mask.
- R10: Mask bit order is bit 0 North, bit 1 East, bit 2 South, bit 3 West, bit 4 Local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 3 | Register select (0..3 = N, E, S, W) |
| cfg_data_i | input | 8 | Configuration write data |
| dx_i | input | OFS_W | Signed X offset to destination |
| dy_i | input | OFS_W | Signed Y offset to destination |
| bcast_i | input | 1 | 1 = broadcast tree mode |
| in_port_i | input | 3 | Arrival port code |
| port_sel_o | output | 5 | Output port mask |

## Verification
The bench keeps the default offset width of 4 bits. It sweeps every X and Y offset from -3 to +3, which covers each sign combination, the zero-offset case and both turn cases for every port. The sweep is repeated across several register loads: the reset state, a failed East link with turns opened on North, a set of adaptive turn permissions, writes with the upper bits set, and writes to unused addresses. Broadcast mode is exercised for every arrival port under full and pruned trees, with nonzero offsets applied to show they are ignored.

// File: rtl/lbdr_pkg.sv
package lbdr_pkg;
  localparam int NUM_DIR = 4;
  localparam int CFG_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int NUM_OUT = NUM_DIR + 1;

  // field positions inside a port register
  localparam int CONN_BIT  = 0;
  localparam int TURN_A    = 1;
  localparam int TURN_B    = 2;
  localparam int TREE_BIT  = 3;

  typedef enum logic [2:0] {
    DIR_N = 3'd0,
    DIR_E = 3'd1,
    DIR_S = 3'd2,
    DIR_W = 3'd3,
    DIR_L = 3'd4
  } dir_e;

  // X-then-Y defaults: vertical ports forbid turns, horizontal allow both
  function automatic logic [CFG_W-1:0] rst_cfg(int d);
    return (d == int'(DIR_E) || d == int'(DIR_W)) ? 8'h0F : 8'h09;
  endfunction
endpackage

// File: rtl/lbdr_cfg_regs.sv
module lbdr_cfg_regs
  import lbdr_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [CFG_W-1:0]                   data_i,
  output logic [NUM_DIR-1:0][CFG_W-1:0]      cfg_o
);
  for (genvar k = 0; k < NUM_DIR; k++) begin : g_reg
    logic hit;
    assign hit = we_i && (addr_i == ADDR_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cfg_o[k] <= rst_cfg(k);
      else if (hit) cfg_o[k] <= data_i;
    end

    // R8
    wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(k)) |=> (cfg_o[k] == $past(data_i)));
    // R8
    wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == ADDR_W'(k)) |=> $stable(cfg_o[k]));
  end
endmodule

// File: rtl/lbdr_unicast.sv
module lbdr_unicast
  import lbdr_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic signed [OFS_W-1:0] dx_i,
  input  logic signed [OFS_W-1:0] dy_i,
  input  logic [NUM_DIR-1:0]      conn_i,
  input  logic [NUM_DIR-1:0]      turn_a_i,
  input  logic [NUM_DIR-1:0]      turn_b_i,
  output logic [NUM_OUT-1:0]      sel_o
);
  logic go_n, go_e, go_s, go_w, no_x, no_y;
  logic [NUM_DIR-1:0] elig;

  assign go_e = dx_i > 0;
  assign go_w = dx_i < 0;
  assign go_n = dy_i > 0;
  assign go_s = dy_i < 0;
  assign no_x = !go_e && !go_w;
  assign no_y = !go_n && !go_s;

  // turn_a: east for vertical ports, north for horizontal ports
  assign elig[DIR_N] = conn_i[DIR_N] && go_n &&
         (no_x || (go_e && turn_a_i[DIR_N]) || (go_w && turn_b_i[DIR_N]));
  assign elig[DIR_S] = conn_i[DIR_S] && go_s &&
         (no_x || (go_e && turn_a_i[DIR_S]) || (go_w && turn_b_i[DIR_S]));
  assign elig[DIR_E] = conn_i[DIR_E] && go_e &&
         (no_y || (go_n && turn_a_i[DIR_E]) || (go_s && turn_b_i[DIR_E]));
  assign elig[DIR_W] = conn_i[DIR_W] && go_w &&
         (no_y || (go_n && turn_a_i[DIR_W]) || (go_s && turn_b_i[DIR_W]));

  always_comb begin
    sel_o = '0;
    if (no_x && no_y)      sel_o[DIR_L] = 1'b1;
    else if (elig[DIR_E])  sel_o[DIR_E] = 1'b1;
    else if (elig[DIR_W])  sel_o[DIR_W] = 1'b1;
    else if (elig[DIR_N])  sel_o[DIR_N] = 1'b1;
    else if (elig[DIR_S])  sel_o[DIR_S] = 1'b1;
  end
endmodule

// File: rtl/lbdr_bcast.sv
module lbdr_bcast
  import lbdr_pkg::*;
(
  input  logic [NUM_DIR-1:0] conn_i,
  input  logic [NUM_DIR-1:0] tree_i,
  input  logic [2:0]         in_port_i,
  output logic [NUM_OUT-1:0] sel_o
);
  logic [NUM_DIR-1:0] from_mask;

  for (genvar k = 0; k < NUM_DIR; k++) begin : g_from
    assign from_mask[k] = (in_port_i == 3'(k));
  end

  assign sel_o = {1'b1, conn_i & tree_i & ~from_mask};
endmodule

// File: rtl/lbdr_route.sv
module lbdr_route
  import lbdr_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [2:0]              cfg_addr_i,
  input  logic [7:0]              cfg_data_i,
  input  logic signed [OFS_W-1:0] dx_i,
  input  logic signed [OFS_W-1:0] dy_i,
  input  logic                    bcast_i,
  input  logic [2:0]              in_port_i,
  output logic [4:0]              port_sel_o
);
  logic [NUM_DIR-1:0][CFG_W-1:0] cfg;
  logic [NUM_DIR-1:0] conn, turn_a, turn_b, tree;
  logic [NUM_OUT-1:0] uni_sel, bc_sel;

  lbdr_cfg_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg)
  );

  for (genvar k = 0; k < NUM_DIR; k++) begin : g_fields
    assign conn[k]   = cfg[k][CONN_BIT];
    assign turn_a[k] = cfg[k][TURN_A];
    assign turn_b[k] = cfg[k][TURN_B];
    assign tree[k]   = cfg[k][TREE_BIT];
  end

  lbdr_unicast #(.OFS_W(OFS_W)) u_uni (
    .dx_i     (dx_i),
    .dy_i     (dy_i),
    .conn_i   (conn),
    .turn_a_i (turn_a),
    .turn_b_i (turn_b),
    .sel_o    (uni_sel)
  );

  lbdr_bcast u_bc (
    .conn_i    (conn),
    .tree_i    (tree),
    .in_port_i (in_port_i),
    .sel_o     (bc_sel)
  );

  assign port_sel_o = bcast_i ? bc_sel : uni_sel;

  // R5
  dead_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_sel_o[3:0] & ~conn) == '0);
  // R6
  uni_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bcast_i |-> $onehot0(port_sel_o));
  // R2
  arrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bcast_i && dx_i == 0 && dy_i == 0) |-> port_sel_o == 5'b10000);
  // R3
  productive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bcast_i |-> ((!port_sel_o[DIR_E] || dx_i > 0) && (!port_sel_o[DIR_W] || dx_i < 0) &&
                  (!port_sel_o[DIR_N] || dy_i > 0) && (!port_sel_o[DIR_S] || dy_i < 0)));
  // R7
  bc_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_i |-> port_sel_o[DIR_L]);
  // R7
  bc_no_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_i && in_port_i < 3'd4) |-> !port_sel_o[in_port_i]);
endmodule

// File: tb/lbdr_route_bench.sv
module lbdr_route_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic signed [3:0] dx = '0, dy = '0;
  logic bc = 1'b0;
  logic [2:0] inp = 3'd4;
  logic [4:0] sel;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mcfg [4];

  always #2.5 clk = ~clk;

  lbdr_route u_lbdr_route (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_data_i(data), .dx_i(dx), .dy_i(dy), .bcast_i(bc),
    .in_port_i(inp), .port_sel_o(sel)
  );

  function automatic logic [4:0] xy_ref(int x, int y);
    if (x > 0) return 5'b00010;
    if (x < 0) return 5'b01000;
    if (y > 0) return 5'b00001;
    if (y < 0) return 5'b00100;
    return 5'b10000;
  endfunction

  // bit order N=0 E=1 S=2 W=3 L=4; cfg bit0 link, bit1/2 turns, bit3 tree
  function automatic logic [4:0] model(int x, int y, bit b, int from);
    logic [4:0] r;
    bit en, ee, es, ew;
    r = '0;
    if (b) begin
      r[4] = 1'b1;
      for (int k = 0; k < 4; k++)
        r[k] = mcfg[k][0] && mcfg[k][3] && (from != k);
      return r;
    end
    if (x == 0 && y == 0) return 5'b10000;
    en = mcfg[0][0] && y > 0 && (x == 0 || (x > 0 && mcfg[0][1]) || (x < 0 && mcfg[0][2]));
    es = mcfg[2][0] && y < 0 && (x == 0 || (x > 0 && mcfg[2][1]) || (x < 0 && mcfg[2][2]));
    ee = mcfg[1][0] && x > 0 && (y == 0 || (y > 0 && mcfg[1][1]) || (y < 0 && mcfg[1][2]));
    ew = mcfg[3][0] && x < 0 && (y == 0 || (y > 0 && mcfg[3][1]) || (y < 0 && mcfg[3][2]));
    if (ee) r[1] = 1'b1;
    else if (ew) r[3] = 1'b1;
    else if (en) r[0] = 1'b1;
    else if (es) r[2] = 1'b1;
    return r;
  endfunction

  task automatic check(string tag, logic [4:0] exp);
    n_chk++;
    if (sel !== exp) begin
      n_bad++;
      $display("FAIL %s dx=%0d dy=%0d bc=%0b in=%0d got=%b exp=%b",
               tag, dx, dy, bc, inp, sel, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; data = d;
    @(negedge clk);
    we = 1'b0;
    if (a < 3'd4) mcfg[a] = d;
  endtask

  task automatic sweep_uni(string tag, bit use_xy);
    bc = 1'b0;
    for (int x = -3; x <= 3; x++) begin
      for (int y = -3; y <= 3; y++) begin
        dx = 4'(x); dy = 4'(y);
        #1;
        check(tag, use_xy ? xy_ref(x, y) : model(x, y, 1'b0, 4));
      end
    end
  endtask

  // R7: offsets varied to show they do not matter
  task automatic sweep_bc(string tag);
    bc = 1'b1;
    for (int f = 0; f < 5; f++) begin
      for (int x = -1; x <= 1; x++) begin
        inp = 3'(f); dx = 4'(x); dy = 4'(-x);
        #1;
        check(tag, model(x, -x, 1'b1, f));
      end
    end
    bc = 1'b0; inp = 3'd4;
  endtask

  initial begin
    for (int k = 0; k < 4; k++) mcfg[k] = (k == 1 || k == 3) ? 8'h0F : 8'h09;
    #12;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state gives X-then-Y; R2 R3 R10 covered in same sweep
    sweep_uni("R1", 1'b1);
    sweep_bc("R7");
    // R5 East link down, R4 North allowed to turn both ways
    wr(3'd1, 8'h0E);
    wr(3'd0, 8'h07);
    sweep_uni("R5", 1'b0);
    sweep_bc("R5");
    // R4 R6 adaptive turns: vertical ports may turn, horizontal may not
    wr(3'd1, 8'h09);
    wr(3'd3, 8'h09);
    wr(3'd2, 8'h07);
    sweep_uni("R4", 1'b0);
    // R6 all turns allowed: X wins when both eligible
    wr(3'd1, 8'h07); wr(3'd3, 8'h07); wr(3'd0, 8'h07); wr(3'd2, 8'h07);
    sweep_uni("R6", 1'b0);
    sweep_bc("R7");
    // R8 unused addresses ignored
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd7, 8'h00);
    sweep_uni("R8", 1'b0);
    // R9 upper bits set, no effect
    wr(3'd0, 8'hF1); wr(3'd1, 8'hA7); wr(3'd2, 8'h5B); wr(3'd3, 8'hF3);
    sweep_uni("R9", 1'b0);
    sweep_bc("R9");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule